// File: doc/BRIEF.md
# Clock Mode Controller

The clock mode controller decides which clocks of a microcontroller run at any moment. It keeps the current operating mode (run, wait, stop or self-clock) in a small state machine. From that mode and a set of live control bits it produces the oscillator enable and the gate enables for the system, core, watchdog and periodic-interrupt clocks.

Wait and stop requests move the block out of run mode, and a wake-up input brings it back. Stop comes in two variants, chosen by a select bit that is captured on entry. Full-stop shuts the oscillator and every clock. Pseudo-stop keeps the oscillator running, and the watchdog and periodic-interrupt clocks then run only if their own run bits are set.

When the clock monitor reports loss of the external clock, the block can switch to a safety self-clock mode, provided both the monitor enable and the self-clock enable are set. On entry it pulses a start request to an external quality checker, and it pulses again after every failed verdict. It goes back to run mode only after a pass. If the loss is reported while either enable is clear, the block sets a sticky flag and stays in its current mode.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in run mode. All clock and oscillator enables are 1, and `self_clk_o`, `chk_start_o` and `loss_flag_o` are 0.
- R2: In run mode every enable output is 1. A request is taken on the next clock edge, with this priority: an enabled loss of clock, then `stop_req_i` (to stop), then `wait_req_i` (to wait).
- R3: In wait mode, `osc_en_o`, `wdog_clk_en_o` and `pint_clk_en_o` are 1. `sys_clk_en_o` is the inverse of `sys_wait_dis_i` and `core_clk_en_o` is the inverse of `core_wait_dis_i`, both following the live inputs.
- R4: The stop variant is sampled from `pstop_sel_i` on the edge that enters stop (0 = full-stop, 1 = pseudo-stop). Changes to `pstop_sel_i` while in stop have no effect.
- R5: In full-stop all five enable outputs are 0.
- R6: In pseudo-stop, `osc_en_o` is 1 and the system and core enables are 0. `wdog_clk_en_o` follows `wdog_run_i` and `pint_clk_en_o` follows `pint_run_i`.
- R7: `wakeup_i` in wait or stop returns the block to run mode on the next edge. It has no effect in run or self-clock mode, and in stop the block ignores `clk_loss_i`.
- R8: `clk_loss_i` in run or wait, with both `mon_en_i` and `self_en_i` set, enters self-clock mode on the next edge. This takes priority over wake-up and over any request. In self-clock mode, `self_clk_o` and all five enables are 1, and wait, stop and wake-up inputs are ignored.
- R9: `chk_start_o` is 1 for exactly the first cycle in self-clock mode. It is 1 again for one cycle after each cycle in self-clock mode with `chk_done_i`=1 and `chk_pass_i`=0, and it is 0 at all other times.
- R10: `chk_done_i`=1 with `chk_pass_i`=1 in self-clock mode returns the block to run mode on the next edge, which clears `self_clk_o`.
- R11: `clk_loss_i` in run or wait, with either enable clear, sets `loss_flag_o` on the next edge and leaves the mode unchanged. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wait_req_i | input | 1 | Request to enter wait mode |
| stop_req_i | input | 1 | Request to enter stop mode |
| wakeup_i | input | 1 | Return from wait or stop to run |
| sys_wait_dis_i | input | 1 | Gate system clock off during wait |
| core_wait_dis_i | input | 1 | Gate core clock off during wait |
| pstop_sel_i | input | 1 | Stop variant select: 0 full, 1 pseudo |
| mon_en_i | input | 1 | Clock monitor enable |
| self_en_i | input | 1 | Self-clock mode enable |
| wdog_run_i | input | 1 | Keep watchdog clock running in pseudo-stop |
| pint_run_i | input | 1 | Keep periodic-interrupt clock running in pseudo-stop |
| clk_loss_i | input | 1 | Loss of external clock reported by the monitor |
| chk_done_i | input | 1 | Quality checker verdict valid |
| chk_pass_i | input | 1 | Quality checker verdict: 1 pass, 0 fail |
| osc_en_o | output | 1 | Oscillator enable |
| sys_clk_en_o | output | 1 | System clock gate enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| wdog_clk_en_o | output | 1 | Watchdog clock gate enable |
| pint_clk_en_o | output | 1 | Periodic-interrupt clock gate enable |
| self_clk_o | output | 1 | Self-clock mode active |
| chk_start_o | output | 1 | Quality check start pulse |
| loss_flag_o | output | 1 | Sticky flag for a loss of clock that was not acted on |

## Verification
Mode changes, the start pulse and the loss flag are all registered, so they appear one edge after the stimulus that causes them. The gate enables are decoded from the registered mode together with the live control bits, so a change to a wait-disable or run bit shows in the same cycle. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge, using the inputs that were present at that edge. It compares every output at the following falling edge, which covers both the one-edge latency and the same-cycle decode.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_SELF = 2'd3
  } mode_e;

  typedef struct packed {
    logic osc;
    logic sys;
    logic core;
    logic wdog;
    logic pint;
  } gate_t;
endpackage

// File: rtl/clk_mode_fsm.sv
module clk_mode_fsm
  import clk_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wait_req_i,
  input  logic  stop_req_i,
  input  logic  wakeup_i,
  input  logic  pstop_sel_i,
  input  logic  loss_act_i,
  input  logic  chk_done_i,
  input  logic  chk_pass_i,
  output mode_e mode_o,
  output logic  pseudo_o,
  output logic  enter_self_o
);
  mode_e mode_q, mode_d;
  logic  pseudo_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (loss_act_i)      mode_d = MODE_SELF;
        else if (stop_req_i) mode_d = MODE_STOP;
        else if (wait_req_i) mode_d = MODE_WAIT;
      end
      MODE_WAIT: begin
        if (loss_act_i)    mode_d = MODE_SELF;
        else if (wakeup_i) mode_d = MODE_RUN;
      end
      MODE_STOP: if (wakeup_i) mode_d = MODE_RUN;
      MODE_SELF: if (chk_done_i && chk_pass_i) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RUN;
      pseudo_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      // variant captured only on stop entry
      if (mode_q != MODE_STOP && mode_d == MODE_STOP) pseudo_q <= pstop_sel_i;
    end
  end

  assign mode_o       = mode_q;
  assign pseudo_o     = pseudo_q;
  assign enter_self_o = (mode_q != MODE_SELF) && (mode_d == MODE_SELF);

  a_r4_variant_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP) |=> (mode_q != MODE_STOP || $stable(pseudo_q)));
  a_r7_wake_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && wakeup_i) |=> (mode_q == MODE_RUN));
  a_r8_self_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_RUN || mode_q == MODE_WAIT) && loss_act_i) |=> (mode_q == MODE_SELF));
  a_r10_pass_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SELF && chk_done_i && chk_pass_i) |=> (mode_q == MODE_RUN));
endmodule

// File: rtl/clk_mode_check_seq.sv
module clk_mode_check_seq
  import clk_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  enter_self_i,
  input  logic  clk_loss_i,
  input  logic  loss_armed_i,
  input  logic  chk_done_i,
  input  logic  chk_pass_i,
  output logic  chk_start_o,
  output logic  loss_flag_o
);
  logic start_q, flag_q;
  logic watch_loss, retry;

  assign watch_loss = (mode_i == MODE_RUN) || (mode_i == MODE_WAIT);
  assign retry      = (mode_i == MODE_SELF) && chk_done_i && !chk_pass_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      start_q <= enter_self_i || retry;
      if (watch_loss && clk_loss_i && !loss_armed_i) flag_q <= 1'b1;
    end
  end

  assign chk_start_o = start_q;
  assign loss_flag_o = flag_q;

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && !retry) |=> !start_q);
  a_r9_start_in_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (mode_i == MODE_SELF));
  a_r11_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
endmodule

// File: rtl/clk_mode_gate_decode.sv
module clk_mode_gate_decode
  import clk_mode_pkg::*;
(
  input  mode_e mode_i,
  input  logic  pseudo_i,
  input  logic  sys_wait_dis_i,
  input  logic  core_wait_dis_i,
  input  logic  wdog_run_i,
  input  logic  pint_run_i,
  output gate_t gate_o
);
  always_comb begin
    gate_o = '{osc: 1'b1, sys: 1'b1, core: 1'b1, wdog: 1'b1, pint: 1'b1};
    unique case (mode_i)
      MODE_WAIT: begin
        gate_o.sys  = !sys_wait_dis_i;
        gate_o.core = !core_wait_dis_i;
      end
      MODE_STOP: begin
        gate_o.osc  = pseudo_i;
        gate_o.sys  = 1'b0;
        gate_o.core = 1'b0;
        gate_o.wdog = pseudo_i && wdog_run_i;
        gate_o.pint = pseudo_i && pint_run_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_req_i,
  input  logic stop_req_i,
  input  logic wakeup_i,
  input  logic sys_wait_dis_i,
  input  logic core_wait_dis_i,
  input  logic pstop_sel_i,
  input  logic mon_en_i,
  input  logic self_en_i,
  input  logic wdog_run_i,
  input  logic pint_run_i,
  input  logic clk_loss_i,
  input  logic chk_done_i,
  input  logic chk_pass_i,
  output logic osc_en_o,
  output logic sys_clk_en_o,
  output logic core_clk_en_o,
  output logic wdog_clk_en_o,
  output logic pint_clk_en_o,
  output logic self_clk_o,
  output logic chk_start_o,
  output logic loss_flag_o
);
  mode_e mode;
  logic  pseudo, enter_self, loss_armed, loss_act;
  gate_t gate;

  assign loss_armed = mon_en_i && self_en_i;
  assign loss_act   = clk_loss_i && loss_armed;

  clk_mode_fsm u_fsm (
    .clk_i, .rst_ni, .wait_req_i, .stop_req_i, .wakeup_i, .pstop_sel_i,
    .loss_act_i (loss_act),
    .chk_done_i, .chk_pass_i,
    .mode_o       (mode),
    .pseudo_o     (pseudo),
    .enter_self_o (enter_self)
  );

  clk_mode_check_seq u_chk (
    .clk_i, .rst_ni,
    .mode_i       (mode),
    .enter_self_i (enter_self),
    .clk_loss_i,
    .loss_armed_i (loss_armed),
    .chk_done_i, .chk_pass_i, .chk_start_o, .loss_flag_o
  );

  clk_mode_gate_decode u_dec (
    .mode_i   (mode),
    .pseudo_i (pseudo),
    .sys_wait_dis_i, .core_wait_dis_i, .wdog_run_i, .pint_run_i,
    .gate_o   (gate)
  );

  assign osc_en_o      = gate.osc;
  assign sys_clk_en_o  = gate.sys;
  assign core_clk_en_o = gate.core;
  assign wdog_clk_en_o = gate.wdog;
  assign pint_clk_en_o = gate.pint;
  assign self_clk_o    = (mode == MODE_SELF);

  a_r5_full_stop_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !(sys_clk_en_o || core_clk_en_o || wdog_clk_en_o || pint_clk_en_o));
  a_r8_self_all_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_clk_o |-> (osc_en_o && sys_clk_en_o && core_clk_en_o && wdog_clk_en_o && pint_clk_en_o));
endmodule

// File: tb/tb_clk_mode_ctrl.sv
module tb_clk_mode_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_LIMIT = 200000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, wakeup = 0, sys_dis = 0, core_dis = 0, pstop = 0;
  logic mon_en = 1, self_en = 1, wdog_run = 0, pint_run = 0, loss = 0, done = 0, pass = 0;
  logic osc_en, sys_en, core_en, wdog_en, pint_en, self_clk, chk_start, loss_flag;

  int nvec = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  // model: 0 run, 1 wait, 2 stop, 3 self
  int  m_mode = 0;
  bit  m_pseudo = 0, m_start = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wait_req_i(wait_req), .stop_req_i(stop_req),
    .wakeup_i(wakeup), .sys_wait_dis_i(sys_dis), .core_wait_dis_i(core_dis),
    .pstop_sel_i(pstop), .mon_en_i(mon_en), .self_en_i(self_en),
    .wdog_run_i(wdog_run), .pint_run_i(pint_run), .clk_loss_i(loss),
    .chk_done_i(done), .chk_pass_i(pass),
    .osc_en_o(osc_en), .sys_clk_en_o(sys_en), .core_clk_en_o(core_en),
    .wdog_clk_en_o(wdog_en), .pint_clk_en_o(pint_en), .self_clk_o(self_clk),
    .chk_start_o(chk_start), .loss_flag_o(loss_flag)
  );

  task automatic chk(string tag, string sig, logic act, logic exp);
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, sig, act, exp, cyc);
    end
  endtask

  task automatic model_edge();
    bit armed = mon_en && self_en;
    int nxt = m_mode;
    bit st = 0;
    case (m_mode)
      0: begin
        if (loss && armed) begin nxt = 3; st = 1; end
        else if (stop_req) begin nxt = 2; m_pseudo = pstop; end
        else if (wait_req) nxt = 1;
        if (loss && !armed) m_flag = 1;
      end
      1: begin
        if (loss && armed) begin nxt = 3; st = 1; end
        else if (wakeup) nxt = 0;
        if (loss && !armed) m_flag = 1;
      end
      2: if (wakeup) nxt = 0;
      default: begin
        if (done && pass) nxt = 0;
        else if (done) st = 1;
      end
    endcase
    m_mode  = nxt;
    m_start = st;
  endtask

  task automatic compare(string tag);
    bit eo = 1, es = 1, ec = 1, ew = 1, ep = 1;
    if (m_mode == 1) begin es = !sys_dis; ec = !core_dis; end
    if (m_mode == 2) begin
      eo = m_pseudo; es = 0; ec = 0;
      ew = m_pseudo && wdog_run; ep = m_pseudo && pint_run;
    end
    nvec++;
    chk(tag, "osc_en", osc_en, eo);
    chk(tag, "sys_en", sys_en, es);
    chk(tag, "core_en", core_en, ec);
    chk(tag, "wdog_en", wdog_en, ew);
    chk(tag, "pint_en", pint_en, ep);
    chk(tag, "self_clk", self_clk, m_mode == 3);
    chk(tag, "chk_start", chk_start, m_start);
    chk(tag, "loss_flag", loss_flag, m_flag);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    wait_req = 0; stop_req = 0; wakeup = 0; loss = 0; done = 0; pass = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after reset");
    step("R2 idle run");
    // R3 wait with both disables, then live change
    wait_req = 1; sys_dis = 1; core_dis = 0; step("R3 wait sys off");
    idle(); sys_dis = 0; core_dis = 1; step("R3 wait core off");
    stop_req = 1; step("R7 stop ignored in wait");
    idle(); wakeup = 1; step("R7 wake from wait");
    idle(); wakeup = 1; step("R7 wake ignored in run");
    // R2 priority stop over wait
    idle(); stop_req = 1; wait_req = 1; pstop = 0; step("R2 stop wins, R5 full stop");
    idle(); pstop = 1; step("R4 select change ignored");
    loss = 1; mon_en = 0; step("R7 loss ignored in stop");
    idle(); mon_en = 1; wakeup = 1; step("R7 wake from stop");
    // R6 pseudo-stop
    idle(); stop_req = 1; pstop = 1; wdog_run = 1; pint_run = 0; step("R6 pseudo wdog");
    idle(); pstop = 0; wdog_run = 0; pint_run = 1; step("R6 pseudo pint, R4 held");
    wakeup = 1; step("R7 wake");
    // R11 unarmed loss
    idle(); loss = 1; self_en = 0; step("R11 flag set no mode change");
    idle(); self_en = 1; step("R11 flag sticky");
    // R8 self entry from wait, priority over wake
    wait_req = 1; step("R3 enter wait");
    idle(); loss = 1; wakeup = 1; step("R8 self entry, R9 first pulse");
    idle(); step("R9 pulse ends");
    wait_req = 1; stop_req = 1; wakeup = 1; step("R8 requests ignored in self");
    idle(); done = 1; pass = 0; step("R9 retry after fail");
    done = 1; pass = 0; step("R9 second retry");
    idle(); step("R9 idle in self");
    done = 1; pass = 1; step("R10 pass exit");
    idle(); step("R10 run after pass");
    // random soak
    for (int i = 0; i < 4000; i++) begin
      wait_req = ($urandom_range(5) == 0);
      stop_req = ($urandom_range(7) == 0);
      wakeup   = ($urandom_range(9) == 0);
      loss     = ($urandom_range(11) == 0);
      done     = ($urandom_range(3) == 0);
      pass     = $urandom_range(1);
      sys_dis  = $urandom_range(1);
      core_dis = $urandom_range(1);
      pstop    = $urandom_range(1);
      wdog_run = $urandom_range(1);
      pint_run = $urandom_range(1);
      mon_en   = ($urandom_range(3) != 0);
      self_en  = ($urandom_range(3) != 0);
      step("R2 R3 R5 R6 R8 R9 R10 R11 random");
    end
    summary();
  end
endmodule